// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block caches virtual-to-physical page translations for data accesses. Its table has 64 entries and is direct mapped: a few virtual address bits just above the page offset pick one entry. The upper virtual address bits are compared with the tag held in that entry. Pages are 8 KB, so the low 13 address bits pass through untouched and are not handled here.

Software fills the table through a register port, one entry at a time. Each entry has two halves, and each half has its own register bank:

- **Match half:** the virtual tag and a valid flag.
- **Translate half:** the physical page number, four access-permission bits and a cache-inhibit flag.

A lookup presents a virtual address with an enable. On the following clock the block returns the following, and holds them until the next enabled lookup:

- a hit flag,
- the physical page number,
- the four permission bits,
- the cache-inhibit flag.

Fault decisions and address muxing belong to the surrounding logic.

Top module: `dtlb_direct_map`

## Requirements
- R1: Reset (rst_n low) clears every valid flag and the registered lookup outputs. A lookup after reset misses until software writes a match half with its valid bit set.
- R2: The lookup outputs change only on the clock edge where lk_en is high. They are presented from the next cycle and held unchanged while lk_en stays low.
- R3: Virtual address bits 18:13 select the entry. lk_hit is 1 only when that entry is valid and its stored tag equals address bits 31:19.
- R4: Every lookup returns the selected entry's page number, permissions and cache-inhibit flag, whether or not it hits.
- R5: Match-bank layout, for both write and read: tag in bits 31:19 and valid in bit 0. Bits 18:1 are ignored on write and read as zero.
- R6: Translate-bank layout, for both write and read: page number in bits 31:13, supervisor-write in bit 9, supervisor-read in bit 8, user-write in bit 7, user-read in bit 6 and cache-inhibit in bit 1. Bits 12:10, 5:2 and 0 are ignored on write and read as zero.
- R7: Register address bits 5:0 select the entry, and bit 8 selects the bank (0 = match, 1 = translate); for example 0x0A00+n and 0x0B00+n. A write changes only the addressed half of the addressed entry.
- R8: While reg_sel is low, reg_rdata is zero and reg_wr has no effect on any entry.
- R9: Writing a match half with bit 0 clear invalidates that entry, so later lookups to it miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_en | input | 1 | Lookup enable |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered hit flag |
| lk_ppn | output | 19 | Registered physical page number |
| lk_ure | output | 1 | Registered user-read permission |
| lk_uwe | output | 1 | Registered user-write permission |
| lk_sre | output | 1 | Registered supervisor-read permission |
| lk_swe | output | 1 | Registered supervisor-write permission |
| lk_ci | output | 1 | Registered cache-inhibit flag |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | Register write strobe (qualified by reg_sel) |
| reg_addr | input | 16 | Register address: bits 5:0 entry, bit 8 bank |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
The bench builds the block with its default parameters: 13-bit page offset, 6 index bits and a 16-bit register address. This gives a 13-bit tag, a 19-bit page number and 64 entries. With these values the first and last entries, an all-ones tag, and an all-zero tag with a valid flag can all be exercised, together with tag mismatches on a shared index. Writes that set every unimplemented bit show that the packing drops those bits. A second reset in the middle of the run shows that the tags survive but no longer hit.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int REG_DW       = 32;
  localparam int MR_VALID_BIT = 0;
  localparam int TR_CI_BIT    = 1;
  localparam int TR_PERM_LSB  = 6;   // user-read 6, user-write 7, sup-read 8, sup-write 9
  localparam int BANK_SEL_BIT = 8;
  localparam int PERM_W       = 4;

  // Packed order matches translate-register bits 9..6
  typedef struct packed {
    logic swe;
    logic sre;
    logic uwe;
    logic ure;
  } perm_t;

  typedef enum logic {
    BANK_MATCH = 1'b0,
    BANK_XLATE = 1'b1
  } bank_e;
endpackage

// File: rtl/dtlb_rst_sync.sv
module dtlb_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/dtlb_entry_store.sv
module dtlb_entry_store
  import dtlb_pkg::*;
#(
  parameter int SET_BITS = 6,
  parameter int TAG_W    = 13,
  parameter int PPN_W    = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_match,
  input  logic                wr_xlate,
  input  logic [SET_BITS-1:0] widx,
  input  logic [TAG_W-1:0]    wtag,
  input  logic                wvalid,
  input  logic [PPN_W-1:0]    wppn,
  input  perm_t               wperm,
  input  logic                wci,
  input  logic [SET_BITS-1:0] ridx,
  output logic [TAG_W-1:0]    rd_tag,
  output logic                rd_valid,
  output logic [PPN_W-1:0]    rd_ppn,
  output perm_t               rd_perm,
  output logic                rd_ci,
  input  logic [SET_BITS-1:0] lidx,
  output logic [TAG_W-1:0]    lk_tag,
  output logic                lk_valid,
  output logic [PPN_W-1:0]    lk_ppn,
  output perm_t               lk_perm,
  output logic                lk_ci
);
  localparam int ENTRIES = 1 << SET_BITS;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] mt_we, tr_we;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic [ENTRIES-1:0] ci_q;

  // Per-entry write enables
  for (genvar g = 0; g < ENTRIES; g++) begin : g_we
    assign mt_we[g] = wr_match && (widx == SET_BITS'(g));
    assign tr_we[g] = wr_xlate && (widx == SET_BITS'(g));
  end

  always_comb begin
    valid_d = valid_q;
    if (wr_match) valid_d[widx] = wvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Payload storage: no reset, written only under its enable
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (mt_we[e]) tag_q[e] <= wtag;
      if (tr_we[e]) begin
        ppn_q[e]  <= wppn;
        perm_q[e] <= wperm;
        ci_q[e]   <= wci;
      end
    end
  end

  assign rd_tag   = tag_q[ridx];
  assign rd_valid = valid_q[ridx];
  assign rd_ppn   = ppn_q[ridx];
  assign rd_perm  = perm_q[ridx];
  assign rd_ci    = ci_q[ridx];

  assign lk_tag   = tag_q[lidx];
  assign lk_valid = valid_q[lidx];
  assign lk_ppn   = ppn_q[lidx];
  assign lk_perm  = perm_q[lidx];
  assign lk_ci    = ci_q[lidx];

  // R5 R9
  match_wr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_match |=> valid_q[$past(widx)] == $past(wvalid));

  // R7
  xlate_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_xlate && !wr_match) |=> $stable(valid_q));
endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
  import dtlb_pkg::*;
#(
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_en,
  input  logic [31:0]         vaddr,
  output logic [SET_BITS-1:0] lidx,
  input  logic [31-PAGE_BITS-SET_BITS:0] sel_tag,
  input  logic                sel_valid,
  input  logic [31-PAGE_BITS:0] sel_ppn,
  input  perm_t               sel_perm,
  input  logic                sel_ci,
  output logic                hit_q,
  output logic [31-PAGE_BITS:0] ppn_q,
  output perm_t               perm_q,
  output logic                ci_q
);
  localparam int TAG_W = 32 - PAGE_BITS - SET_BITS;
  localparam int PPN_W = 32 - PAGE_BITS;

  logic             hit_d;
  logic [TAG_W-1:0] va_tag;

  assign lidx   = vaddr[PAGE_BITS +: SET_BITS];
  assign va_tag = vaddr[31 -: TAG_W];
  assign hit_d  = sel_valid && (sel_tag == va_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      ppn_q  <= '0;
      perm_q <= '0;
      ci_q   <= 1'b0;
    end else if (lk_en) begin
      hit_q  <= hit_d;
      ppn_q  <= sel_ppn;
      perm_q <= sel_perm;
      ci_q   <= sel_ci;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> $stable({hit_q, ppn_q, perm_q, ci_q}));

  // R3
  invalid_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !sel_valid) |=> !hit_q);
endmodule

// File: rtl/dtlb_reg_port.sv
module dtlb_reg_port
  import dtlb_pkg::*;
#(
  parameter int REG_AW   = 16,
  parameter int SET_BITS = 6,
  parameter int TAG_W    = 13,
  parameter int PPN_W    = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  output logic                wr_match,
  output logic                wr_xlate,
  output logic [SET_BITS-1:0] idx,
  output logic [TAG_W-1:0]    wtag,
  output logic                wvalid,
  output logic [PPN_W-1:0]    wppn,
  output perm_t               wperm,
  output logic                wci,
  input  logic [TAG_W-1:0]    rd_tag,
  input  logic                rd_valid,
  input  logic [PPN_W-1:0]    rd_ppn,
  input  perm_t               rd_perm,
  input  logic                rd_ci
);
  bank_e bank;

  assign bank     = bank_e'(reg_addr[BANK_SEL_BIT]);
  assign idx      = reg_addr[SET_BITS-1:0];
  assign wr_match = reg_sel && reg_wr && (bank == BANK_MATCH);
  assign wr_xlate = reg_sel && reg_wr && (bank == BANK_XLATE);

  assign wtag   = reg_wdata[REG_DW-1 -: TAG_W];
  assign wvalid = reg_wdata[MR_VALID_BIT];
  assign wppn   = reg_wdata[REG_DW-1 -: PPN_W];
  assign wperm  = perm_t'(reg_wdata[TR_PERM_LSB +: PERM_W]);
  assign wci    = reg_wdata[TR_CI_BIT];

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      if (bank == BANK_MATCH) begin
        reg_rdata[REG_DW-1 -: TAG_W] = rd_tag;
        reg_rdata[MR_VALID_BIT]      = rd_valid;
      end else begin
        reg_rdata[REG_DW-1 -: PPN_W]       = rd_ppn;
        reg_rdata[TR_PERM_LSB +: PERM_W]   = rd_perm;
        reg_rdata[TR_CI_BIT]               = rd_ci;
      end
    end
  end

  // R5
  match_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && (bank == BANK_MATCH)) |-> reg_rdata[REG_DW-TAG_W-1:1] == '0);

  // R6
  xlate_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && (bank == BANK_XLATE)) |->
      (reg_rdata[12:10] == 3'b000 && reg_rdata[5:2] == 4'b0000 && !reg_rdata[0]));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata == '0 && !wr_match && !wr_xlate));
endmodule

// File: rtl/dtlb_direct_map.sv
module dtlb_direct_map
  import dtlb_pkg::*;
#(
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 6,
  parameter int REG_AW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_en,
  input  logic [31:0]              lk_vaddr,
  output logic                     lk_hit,
  output logic [31-PAGE_BITS:0]    lk_ppn,
  output logic                     lk_ure,
  output logic                     lk_uwe,
  output logic                     lk_sre,
  output logic                     lk_swe,
  output logic                     lk_ci,
  input  logic                     reg_sel,
  input  logic                     reg_wr,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata
);
  localparam int TAG_W = 32 - PAGE_BITS - SET_BITS;
  localparam int PPN_W = 32 - PAGE_BITS;

  logic                rst_int_n;
  logic                wr_match, wr_xlate, wvalid, wci;
  logic [SET_BITS-1:0] ridx, lidx;
  logic [TAG_W-1:0]    wtag, rd_tag, sel_tag;
  logic [PPN_W-1:0]    wppn, rd_ppn, sel_ppn;
  perm_t               wperm, rd_perm, sel_perm, perm_q;
  logic                rd_valid, rd_ci, sel_valid, sel_ci;

  dtlb_rst_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_n       (rst_int_n)
  );

  dtlb_reg_port #(
    .REG_AW(REG_AW), .SET_BITS(SET_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wr_match  (wr_match),
    .wr_xlate  (wr_xlate),
    .idx       (ridx),
    .wtag      (wtag),
    .wvalid    (wvalid),
    .wppn      (wppn),
    .wperm     (wperm),
    .wci       (wci),
    .rd_tag    (rd_tag),
    .rd_valid  (rd_valid),
    .rd_ppn    (rd_ppn),
    .rd_perm   (rd_perm),
    .rd_ci     (rd_ci)
  );

  dtlb_entry_store #(
    .SET_BITS(SET_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_match (wr_match),
    .wr_xlate (wr_xlate),
    .widx     (ridx),
    .wtag     (wtag),
    .wvalid   (wvalid),
    .wppn     (wppn),
    .wperm    (wperm),
    .wci      (wci),
    .ridx     (ridx),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .rd_ppn   (rd_ppn),
    .rd_perm  (rd_perm),
    .rd_ci    (rd_ci),
    .lidx     (lidx),
    .lk_tag   (sel_tag),
    .lk_valid (sel_valid),
    .lk_ppn   (sel_ppn),
    .lk_perm  (sel_perm),
    .lk_ci    (sel_ci)
  );

  dtlb_lookup #(
    .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS)
  ) u_lookup (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lk_en     (lk_en),
    .vaddr     (lk_vaddr),
    .lidx      (lidx),
    .sel_tag   (sel_tag),
    .sel_valid (sel_valid),
    .sel_ppn   (sel_ppn),
    .sel_perm  (sel_perm),
    .sel_ci    (sel_ci),
    .hit_q     (lk_hit),
    .ppn_q     (lk_ppn),
    .perm_q    (perm_q),
    .ci_q      (lk_ci)
  );

  assign lk_ure = perm_q.ure;
  assign lk_uwe = perm_q.uwe;
  assign lk_sre = perm_q.sre;
  assign lk_swe = perm_q.swe;
endmodule

// File: tb/test_dtlb_direct_map.sv
module test_dtlb_direct_map;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_en;
  logic [31:0] lk_vaddr;
  logic        lk_hit, lk_ure, lk_uwe, lk_sre, lk_swe, lk_ci;
  logic [18:0] lk_ppn;
  logic        reg_sel, reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dtlb_direct_map i_dtlb_direct_map (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ure(lk_ure), .lk_uwe(lk_uwe),
    .lk_sre(lk_sre), .lk_swe(lk_swe), .lk_ci(lk_ci),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  localparam logic [15:0] MB = 16'h0A00;
  localparam logic [15:0] TB = 16'h0B00;
  localparam logic [31:0] JUNK_M = 32'h0007_FFFE;  // bits 18:1
  localparam logic [31:0] JUNK_T = 32'h0000_1C3D;  // bits 12:10, 5:2, 0

  function automatic logic [31:0] mr(input logic [12:0] tag, input logic v);
    return {tag, 18'b0, v};
  endfunction

  // perm nibble = {swe, sre, uwe, ure}
  function automatic logic [31:0] tr(input logic [18:0] ppn, input logic [3:0] pm, input logic ci);
    return {ppn, 3'b0, pm, 4'b0, ci, 1'b0};
  endfunction

  // vector: {vaddr[32], hit, ppn[19], perm[4], ci}
  localparam int NV = 6;
  localparam logic [56:0] VEC [NV] = '{
    {13'h0A5B, 6'd5,  13'h1FFF, 1'b1, 19'h12345, 4'b1101, 1'b1},
    {13'h0A5C, 6'd5,  13'h0000, 1'b0, 19'h12345, 4'b1101, 1'b1},
    {13'h1FFF, 6'd63, 13'h0000, 1'b1, 19'h7FFFF, 4'b1010, 1'b0},
    {13'h0000, 6'd0,  13'h0010, 1'b1, 19'h00001, 4'b0101, 1'b0},
    {13'h0003, 6'd9,  13'h0000, 1'b0, 19'h55555, 4'b1111, 1'b1},
    {13'h1FFF, 6'd0,  13'h0ABC, 1'b0, 19'h00001, 4'b0101, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rreg(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 check(req, {32'b0, reg_rdata}, {32'b0, exp});
    reg_sel = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic eh,
                      input logic [18:0] ep, input logic [3:0] epm, input logic eci);
    @(negedge clk);
    lk_en = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_en = 1'b0;
    check({req, " hit"},  {63'b0, lk_hit}, {63'b0, eh});
    check({req, " ppn"},  {45'b0, lk_ppn}, {45'b0, ep});
    check({req, " perm"}, {60'b0, lk_swe, lk_sre, lk_uwe, lk_ure}, {60'b0, epm});
    check({req, " ci"},   {63'b0, lk_ci}, {63'b0, eci});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_en = 1'b0; lk_vaddr = '0;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 reset hit", {63'b0, lk_hit}, 64'd0);
    check("R1 reset ci",  {63'b0, lk_ci},  64'd0);
    check("R8 idle rdata", {32'b0, reg_rdata}, 64'd0);
    @(negedge clk); lk_en = 1'b1; lk_vaddr = 32'h0000_0000;
    @(negedge clk); lk_en = 1'b0;
    check("R1 empty miss", {63'b0, lk_hit}, 64'd0);

    // Preload, junk in unimplemented bits (R5 R6)
    wreg(MB + 16'd5,  mr(13'h0A5B, 1'b1) | JUNK_M);
    wreg(TB + 16'd5,  tr(19'h12345, 4'b1101, 1'b1) | JUNK_T);
    wreg(MB + 16'd63, mr(13'h1FFF, 1'b1));
    wreg(TB + 16'd63, tr(19'h7FFFF, 4'b1010, 1'b0));
    wreg(MB + 16'd0,  mr(13'h0000, 1'b1));
    wreg(TB + 16'd0,  tr(19'h00001, 4'b0101, 1'b0));
    wreg(MB + 16'd9,  mr(13'h0003, 1'b0));
    wreg(TB + 16'd9,  tr(19'h55555, 4'b1111, 1'b1));

    rreg("R5 match readback", MB + 16'd5, mr(13'h0A5B, 1'b1));
    rreg("R6 xlate readback", TB + 16'd5, tr(19'h12345, 4'b1101, 1'b1));
    rreg("R7 match kept after xlate write", MB + 16'd9, mr(13'h0003, 1'b0));
    rreg("R7 last entry xlate", TB + 16'd63, tr(19'h7FFFF, 4'b1010, 1'b0));

    // R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      look("R3 R4 vector", VEC[i][56:25], VEC[i][24], VEC[i][23:5], VEC[i][4:1], VEC[i][0]);
    end

    // R2: outputs hold while lk_en low
    look("R2 setup", {13'h1FFF, 6'd63, 13'h0}, 1'b1, 19'h7FFFF, 4'b1010, 1'b0);
    lk_vaddr = {13'h0003, 6'd9, 13'h0};
    repeat (3) @(negedge clk);
    check("R2 hold hit", {63'b0, lk_hit}, 64'd1);
    check("R2 hold ppn", {45'b0, lk_ppn}, {45'b0, 19'h7FFFF});

    // R8: write while deselected is ignored
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_addr = MB + 16'd5; reg_wdata = mr(13'h0111, 1'b0);
    #1 check("R8 rdata zero when deselected", {32'b0, reg_rdata}, 64'd0);
    @(negedge clk); reg_wr = 1'b0;
    rreg("R8 entry unchanged", MB + 16'd5, mr(13'h0A5B, 1'b1));

    // R9: invalidate entry 5
    wreg(MB + 16'd5, mr(13'h0A5B, 1'b0));
    look("R9 invalidated", {13'h0A5B, 6'd5, 13'h0}, 1'b0, 19'h12345, 4'b1101, 1'b1);

    // R1: second reset clears valid but not payload
    do_reset();
    check("R1 reset outputs", {63'b0, lk_hit}, 64'd0);
    look("R1 miss after reset", {13'h1FFF, 6'd63, 13'h0}, 1'b0, 19'h7FFFF, 4'b1010, 1'b0);
    rreg("R1 valid cleared", MB + 16'd63, mr(13'h1FFF, 1'b0));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule